// File: doc/BRIEF.md
# Master Clock Rate Detector

This block works out which master clock frequency is feeding a voice codec. It counts master-clock cycles between successive rising edges of the 8 kHz frame sync. It then sorts each measured frame length into one of four clock rates: 8.192 MHz, 4.096 MHz, 2.048 MHz, or the 1.536/1.544 MHz pair. The resulting rate code and a valid flag go to every channel of the device. One selection serves all channels.

No configuration pin sets the rate. A frame of 192 cycles and a frame of 193 cycles share the same rate code, but a separate flag tells them apart. A rate counts as settled only when several successive frames agree. The block withdraws the valid flag in three cases:
- a frame falls outside every tolerance window;
- the classification changes;
- the frame sync stops.

The code last agreed on stays on the output in all of these cases.

Top module: `mclk_rate_detect`

## Requirements
- R1: While `rst` is high and after its release, `rate_valid`, `rate_code` and `rate_193` are all 0.
- R2: A frame length of 1024 cycles maps to rate code 0, 512 to code 1, 256 to code 2, and 192 or 193 to code 3.
- R3: A frame length within one cycle of a nominal length is classified as that nominal length (for example 1023 and 1025 give code 0, and 255 and 257 give code 2).
- R4: `rate_193` is 1 when the locked frame length is 193 or 194 cycles, and 0 when it is 191 or 192 cycles. It is only ever 1 together with code 3. It changes only in the cycle in which a new lock is reached.
- R5: The first sync edge after reset only starts the count. `rate_valid` rises only at a sync rising edge that completes the third consecutive measured frame with the same classification (code and 193 flag). After two matching frames it is still 0.
- R6: A measured frame length outside every tolerance window clears `rate_valid` in the cycle after that sync edge. `rate_code` and `rate_193` keep their previous values.
- R7: A measured frame that falls in a different window from the one before it clears `rate_valid`, and the old code and flag are held. The new code is taken only after three consecutive frames of the new class.
- R8: If 1100 clock cycles pass after a sync rising edge with no new rising edge, `rate_valid` falls at the 1100th rising clock edge after the sync and the code is held. A sync arriving exactly at that cycle is measured as 1100 cycles, which is out of range.
- R9: Only the rising edge of `fsync` marks a frame. The width of the sync pulse has no effect on the measured length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock whose rate is being detected |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | 8 kHz frame sync, synchronous to `clk`; rising edge marks a frame |
| rate_code | output | 2 | Detected rate: 0 = 1024, 1 = 512, 2 = 256, 3 = 192/193 cycles per frame |
| rate_193 | output | 1 | Set when the locked frame is the 193-cycle variant |
| rate_valid | output | 1 | Rate has been confirmed by three consistent frames and sync is present |

## Verification
Two things can fall on the same clock edge: the silence timeout and the measurement of a frame. This happens when a sync rising edge arrives exactly 1100 cycles after the previous one, so the counter reaches its limit on the very edge that closes the frame. The bench provokes this by holding the sync low for exactly 1100 cycles after a locked 256-cycle stream, then resuming. It judges the result by checking three things: the valid flag is low after that edge, the old code is still present, and three further 256-cycle frames bring the lock back. Separately, the bench samples one cycle before and one cycle after the 1100-cycle boundary to pin down the exact edge at which the timeout acts.

// File: rtl/mclk_rate_pkg.sv
package mclk_rate_pkg;

    typedef logic [1:0] rate_code_t;

    // Classification result of one measured frame
    typedef struct packed {
        logic       hit;   // length fell inside a window
        rate_code_t code;  // rate code of that window
        logic       ext;   // 193-cycle variant
    } rate_class_t;

    // Nominal frame lengths, in priority order
    localparam int NUM_RATES = 5;

    function automatic int nominal_len(input int idx);
        case (idx)
            0:       return 1024;
            1:       return 512;
            2:       return 256;
            3:       return 192;
            default: return 193;
        endcase
    endfunction

    function automatic rate_code_t nominal_code(input int idx);
        return (idx >= 3) ? rate_code_t'(3) : rate_code_t'(idx);
    endfunction

    function automatic logic nominal_ext(input int idx);
        return (idx == 4);
    endfunction

    // The 192 and 193 windows meet without overlap: 192 owns the
    // lower side, 193 owns the upper side.
    function automatic int window_lo(input int idx, input int tol);
        return (idx == 4) ? nominal_len(idx) : nominal_len(idx) - tol;
    endfunction

    function automatic int window_hi(input int idx, input int tol);
        return (idx == 3) ? nominal_len(idx) : nominal_len(idx) + tol;
    endfunction

endpackage

// File: rtl/fs_rise_detect.sv
module fs_rise_detect (
    input  logic clk,
    input  logic rst,
    input  logic fsync,
    output logic sync_rise
);
    logic fs_q;

    always_ff @(posedge clk) begin
        if (rst) fs_q <= 1'b0;
        else     fs_q <= fsync;
    end

    assign sync_rise = fsync & ~fs_q;
endmodule

// File: rtl/frame_len_counter.sv
module frame_len_counter #(
    parameter int CNT_W       = 11,
    parameter int TIMEOUT_CYC = 1100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_rise,
    output logic [CNT_W-1:0] frame_len,
    output logic             have_ref,
    output logic             timed_out
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYC);

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_len <= '0;
            have_ref  <= 1'b0;
        end else if (sync_rise) begin
            frame_len <= CNT_W'(1);
            have_ref  <= 1'b1;
        end else if (frame_len < LIMIT) begin
            frame_len <= frame_len + CNT_W'(1);
        end
    end

    assign timed_out = (frame_len >= LIMIT);
endmodule

// File: rtl/rate_window_classify.sv
module rate_window_classify
    import mclk_rate_pkg::*;
#(
    parameter int CNT_W = 11,
    parameter int TOL   = 1
) (
    input  logic [CNT_W-1:0] frame_len,
    output rate_class_t      cls
);
    logic [NUM_RATES-1:0] in_win;

    for (genvar gi = 0; gi < NUM_RATES; gi++) begin : g_win
        localparam int LO = window_lo(gi, TOL);
        localparam int HI = window_hi(gi, TOL);
        assign in_win[gi] = (int'(frame_len) >= LO) && (int'(frame_len) <= HI);
    end

    // Lowest index wins should windows ever touch
    always_comb begin
        cls = '0;
        for (int i = NUM_RATES - 1; i >= 0; i--) begin
            if (in_win[i]) begin
                cls.hit  = 1'b1;
                cls.code = nominal_code(i);
                cls.ext  = nominal_ext(i);
            end
        end
    end
endmodule

// File: rtl/rate_lock_tracker.sv
module rate_lock_tracker
    import mclk_rate_pkg::*;
#(
    parameter int LOCK_FRAMES = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        meas_stb,
    input  rate_class_t cls,
    input  logic        timed_out,
    output rate_code_t  code_o,
    output logic        ext_o,
    output logic        valid_o
);
    localparam int SW = $clog2(LOCK_FRAMES + 1);
    localparam logic [SW-1:0] LOCK_N = SW'(LOCK_FRAMES);

    rate_class_t   last_q;
    logic [SW-1:0] streak_q, streak_d;
    logic          same;

    assign same = (streak_q != '0) && (cls.code == last_q.code) && (cls.ext == last_q.ext);

    always_comb begin
        streak_d = streak_q;
        if (meas_stb) begin
            if (!cls.hit)            streak_d = '0;
            else if (!same)          streak_d = SW'(1);
            else if (streak_q < LOCK_N) streak_d = streak_q + SW'(1);
        end else if (timed_out) begin
            streak_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q   <= '0;
            streak_q <= '0;
            code_o   <= '0;
            ext_o    <= 1'b0;
            valid_o  <= 1'b0;
        end else begin
            streak_q <= streak_d;
            valid_o  <= (streak_d == LOCK_N);
            if (meas_stb && cls.hit) last_q <= cls;
            if (meas_stb && cls.hit && streak_d == LOCK_N) begin
                code_o <= cls.code;
                ext_o  <= cls.ext;
            end
        end
    end
endmodule

// File: rtl/mclk_rate_detect.sv
module mclk_rate_detect
    import mclk_rate_pkg::*;
#(
    parameter int TIMEOUT_CYC = 1100,
    parameter int LOCK_FRAMES = 3,
    parameter int TOL         = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fsync,
    output logic [1:0] rate_code,
    output logic       rate_193,
    output logic       rate_valid
);
    localparam int MAX_LEN = (TIMEOUT_CYC > 1024 + TOL) ? TIMEOUT_CYC : 1024 + TOL;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    logic             sync_rise;
    logic [CNT_W-1:0] frame_len;
    logic             have_ref;
    logic             timed_out;
    rate_class_t      cls;
    rate_code_t       code_w;

    fs_rise_detect u_rise (
        .clk       (clk),
        .rst       (rst),
        .fsync     (fsync),
        .sync_rise (sync_rise)
    );

    frame_len_counter #(.CNT_W(CNT_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .sync_rise (sync_rise),
        .frame_len (frame_len),
        .have_ref  (have_ref),
        .timed_out (timed_out)
    );

    rate_window_classify #(.CNT_W(CNT_W), .TOL(TOL)) u_cls (
        .frame_len (frame_len),
        .cls       (cls)
    );

    rate_lock_tracker #(.LOCK_FRAMES(LOCK_FRAMES)) u_lock (
        .clk       (clk),
        .rst       (rst),
        .meas_stb  (sync_rise & have_ref),
        .cls       (cls),
        .timed_out (timed_out),
        .code_o    (code_w),
        .ext_o     (rate_193),
        .valid_o   (rate_valid)
    );

    assign rate_code = code_w;
endmodule

// File: rtl/mclk_rate_detect_chk.sv
module mclk_rate_detect_chk #(
    parameter int TIMEOUT_CYC = 1100
) (
    input logic       clk,
    input logic       rst,
    input logic       fsync,
    input logic [1:0] rate_code,
    input logic       rate_193,
    input logic       rate_valid
);
    localparam int GW = $clog2(TIMEOUT_CYC + 2);

    logic          fs_prev;
    logic [GW-1:0] gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            fs_prev <= 1'b0;
            gap     <= '0;
        end else begin
            fs_prev <= fsync;
            if (fsync && !fs_prev)            gap <= '0;
            else if (gap < GW'(TIMEOUT_CYC)) gap <= gap + GW'(1);
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk) rst |=> !rate_valid && rate_code == 2'd0 && !rate_193);

    a_r5_valid_rises_on_sync: assert property (@(posedge clk) disable iff (rst)
        $rose(rate_valid) |-> ($past(fsync) && !$past(fsync, 2)));

    a_r7_code_moves_only_at_lock: assert property (@(posedge clk) disable iff (rst)
        !$stable(rate_code) |-> $rose(rate_valid));

    a_r4_flag_moves_only_at_lock: assert property (@(posedge clk) disable iff (rst)
        !$stable(rate_193) |-> $rose(rate_valid));

    a_r4_flag_implies_code3: assert property (@(posedge clk) disable iff (rst)
        rate_193 |-> rate_code == 2'd3);

    a_r8_silence_drops_valid: assert property (@(posedge clk) disable iff (rst)
        (gap >= GW'(TIMEOUT_CYC)) |-> !rate_valid);
endmodule

bind mclk_rate_detect mclk_rate_detect_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .fsync      (fsync),
    .rate_code  (rate_code),
    .rate_193   (rate_193),
    .rate_valid (rate_valid)
);

// File: tb/mclk_rate_detect_bench.sv
module mclk_rate_detect_bench;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 190000;

    typedef struct packed {
        int         gap;
        logic [1:0] code;
        logic       ext;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1024, 2'd0, 1'b0}, '{1023, 2'd0, 1'b0}, '{1025, 2'd0, 1'b0},
        '{512,  2'd1, 1'b0}, '{511,  2'd1, 1'b0}, '{513,  2'd1, 1'b0},
        '{256,  2'd2, 1'b0}, '{255,  2'd2, 1'b0}, '{257,  2'd2, 1'b0},
        '{192,  2'd3, 1'b0}, '{191,  2'd3, 1'b0}, '{193,  2'd3, 1'b1},
        '{194,  2'd3, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst;
    logic       fsync;
    logic [1:0] rate_code;
    logic       rate_193;
    logic       rate_valid;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mclk_rate_detect u_mclk_rate_detect (
        .clk        (clk),
        .rst        (rst),
        .fsync      (fsync),
        .rate_code  (rate_code),
        .rate_193   (rate_193),
        .rate_valid (rate_valid)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_out(input string req, input int v, input int c, input int e);
        chk({req, " valid"}, int'(rate_valid), v);
        chk({req, " code"},  int'(rate_code),  c);
        chk({req, " 193"},   int'(rate_193),   e);
    endtask

    // one-cycle sync pulse, next pulse g cycles later
    task automatic pulse(input int g);
        fsync = 1'b1;
        @(negedge clk);
        fsync = 1'b0;
        repeat (g - 1) @(negedge clk);
    endtask

    // wide sync pulse of w cycles, period g
    task automatic wide_pulse(input int g, input int w);
        fsync = 1'b1;
        repeat (w) @(negedge clk);
        fsync = 1'b0;
        repeat (g - w) @(negedge clk);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [1:0] prev_code;
        logic       prev_ext;
        rst   = 1'b1;
        fsync = 1'b0;
        repeat (4) @(negedge clk);
        chk_out("R1 in reset", 0, 0, 0);
        rst = 1'b0;
        @(negedge clk);
        chk_out("R1 after release", 0, 0, 0);

        // Table walk: a bad frame, then three matching frames
        prev_code = 2'd0;
        prev_ext  = 1'b0;
        for (int i = 0; i < NV; i++) begin
            pulse(100);
            for (int k = 0; k < 3; k++) pulse(VECS[i].gap);
            // two matching frames measured: not yet valid, old code held (R5, R7)
            chk_out($sformatf("R5 pre-lock gap %0d", VECS[i].gap), 0, prev_code, prev_ext);
            pulse(VECS[i].gap);
            // R2 R3 R4 lock on third frame
            chk_out($sformatf("R2 R3 R4 lock gap %0d", VECS[i].gap), 1, VECS[i].code, VECS[i].ext);
            prev_code = VECS[i].code;
            prev_ext  = VECS[i].ext;
        end

        // R7: direct class change from 194 to 1024
        pulse(1024);
        chk_out("R7 still locked", 1, 3, 1);
        pulse(1024);
        chk_out("R7 change drops valid", 0, 3, 1);
        pulse(1024);
        pulse(1024);
        chk_out("R7 relock", 1, 0, 0);

        // R6: lock at 512, then an out-of-window frame
        pulse(512);
        pulse(512);
        pulse(512);
        pulse(512);
        chk_out("R6 locked 512", 1, 1, 0);
        pulse(700);
        pulse(512);
        chk_out("R6 miss holds code", 0, 1, 0);

        // R8: timeout boundary
        pulse(512);
        pulse(512);
        pulse(512);
        chk_out("R8 relocked", 1, 1, 0);
        pulse(1100);
        chk("R8 valid at 1099", int'(rate_valid), 1);
        @(negedge clk);
        chk_out("R8 valid gone at 1100", 0, 1, 0);

        // R9: wide pulses
        for (int k = 0; k < 4; k++) wide_pulse(256, 6);
        chk_out("R9 wide pulse lock", 1, 2, 0);

        // R8: sync exactly at the timeout edge
        pulse(1100);
        pulse(256);
        chk_out("R8 sync at timeout", 0, 2, 0);
        pulse(256);
        pulse(256);
        pulse(256);
        chk_out("R8 recovery", 1, 2, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule